// File: doc/BRIEF.md
# Serial Audio Receive Frame-Alignment Tracker

This block is the receive side of a serial audio port running as a clock slave. The external bit clock is its clock. On every edge it samples the frame-sync line and one or more data lines, and it treats each run of 32 bit clocks as one slot. At the end of each slot it emits the received word from every data line, bit-reversed so that the first serial bit becomes the MSB. The output carries the slot position and a one-bit frame bank tag.

The block does not trust the frame-sync line blindly. At the end of every slot it compares the last 32 samples of frame sync against the pattern that belongs to that slot. Two-channel (I2S) mode checks both halves of the frame. TDM mode checks only the rising edge of frame sync, in the last slot, because the falling edge may move. A mismatch produces a one-cycle loss-of-sync pulse, bumps a saturating error tally and sends the tracker back to hunting. While hunting, no samples come out. When a valid edge pattern appears again, the word that just finished is released as the last slot of the previous frame, and tracking restarts at slot 0.

Top module: `serial_audio_sync_rx`

## Requirements
- R1: While and just after synchronous reset, `locked`, `sample_valid`, `sync_lost` and `err_count` are all 0, and the tracker is hunting.
- R2: Each slot is 32 bit clocks. The first serial bit of a slot appears as bit 31 of that line's sample. Line l occupies `sample_data[32*l +: 32]`.
- R3: With `tdm_mode`=0, the frame-sync word of slot 0 (left) must be 0x7FFFFFFF. Bit 31 is the newest sample: frame sync is high for the first 31 bit clocks of the slot and low on the last one.
- R4: With `tdm_mode`=0, the frame-sync word of slot 1 (right) must be 0x80000000: low for 31 bit clocks, then high on the last.
- R5: With `tdm_mode`=1, only slot CPF-1 is checked. Its two newest frame-sync samples (bits 31:30) must be binary 10. The width of the high pulse and any activity in other slots cause no error.
- R6: A pattern mismatch gives a one-cycle `sync_lost` pulse, no sample for that slot and `locked`=0 in the same cycle. The tracker then hunts.
- R7: While hunting, no sample is emitted. Hunting ends at the first bit clock where the frame-sync word equals 0x80000000 (I2S) or its bits 31:30 are 10 (TDM). The next bit clock starts slot 0.
- R8: The word completed on the bit clock that ends hunting is emitted as the last slot (1 in I2S, CPF-1 in TDM) with `sample_bank`=1, as the previous frame. The frame that follows has bank 0, and the bank toggles after every frame.
- R9: `sample_slot` gives the slot position of the word, so line l carries channel l*CPF+slot. In I2S mode, slot 0 is the left (even) word and slot 1 the right (odd) word.
- R10: `sample_valid` is high for exactly one cycle: the cycle after the edge that samples a slot's last bit. `sync_lost` obeys the same timing rule.
- R11: `err_count` counts mismatches and stays at 255 once there. `err_clear` zeroes it on the next edge and wins over a same-cycle increment.
- R12: The slot position wraps after 2 slots in I2S mode and after CPF slots in TDM mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tdm_mode | input | 1 | 0 selects two-slot I2S rules, 1 selects TDM rules |
| fsync_in | input | 1 | Frame-sync line sample |
| sdata_in | input | LINES | Serial data lines |
| err_clear | input | 1 | Clears the error tally |
| sample_valid | output | 1 | One-cycle strobe for a new set of words |
| sample_slot | output | $clog2(CPF) | Slot position of the words |
| sample_bank | output | 1 | Frame bank tag |
| sample_data | output | 32*LINES | Received words, line 0 in the low 32 bits |
| sync_lost | output | 1 | One-cycle pulse on a frame-sync mismatch |
| locked | output | 1 | High while tracking frame alignment |
| err_count | output | ERR_W | Saturating mismatch tally |

## Verification
The bench builds the block with CPF=4 and LINES=2. With four TDM slots, the TDM check slot (3) is a different slot from the I2S wrap point (1). Two lines show that each word lands at the right position. With the default 8-bit tally, a few hundred forced I2S mismatches drive it into saturation. Randomised pulse widths, data and glitch positions cover the ignored falling edge and mismatches at varied bits.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  localparam int unsigned WORD_W = 32;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } trk_state_t;

  function automatic logic [WORD_W-1:0] rev_word(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/ssm_capture.sv
// Serial-to-word capture: the newest sample enters at the MSB, so the
// snapshot of the last 32 samples is always available combinationally.
module ssm_capture #(
  parameter int LINES = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            fs_bit,
  input  logic [LINES-1:0]                sd_bits,
  output logic [ssm_pkg::WORD_W-1:0]       fs_word,
  output logic [LINES*ssm_pkg::WORD_W-1:0] sd_words
);
  localparam int W = ssm_pkg::WORD_W;

  logic [W-2:0] fs_hist;

  // Preset to ones so no edge pattern can appear before real samples arrive.
  always_ff @(posedge clk) begin
    if (rst) fs_hist <= '1;
    else     fs_hist <= {fs_bit, fs_hist[W-2:1]};
  end
  assign fs_word = {fs_bit, fs_hist};

  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [W-2:0] hist;
    always_ff @(posedge clk) begin
      if (rst) hist <= '0;
      else     hist <= {sd_bits[l], hist[W-2:1]};
    end
    assign sd_words[l*W +: W] = {sd_bits[l], hist};
  end
endmodule

// File: rtl/ssm_tracker.sv
// Slot/frame tracker with per-slot frame-sync pattern checks and hunting.
module ssm_tracker #(
  parameter int CPF    = 4,
  localparam int SLOT_W = $clog2(CPF)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tdm_mode,
  input  logic [ssm_pkg::WORD_W-1:0] fs_word,
  output logic                      emit,
  output logic [SLOT_W-1:0]         emit_slot,
  output logic                      emit_bank,
  output logic                      lost,
  output logic                      tracking
);
  import ssm_pkg::*;
  localparam int W     = WORD_W;
  localparam int CNT_W = $clog2(W);
  localparam logic [W-1:0] PAT_RISE_END = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] PAT_FALL_END = {1'b0, {(W-1){1'b1}}};

  trk_state_t        state;
  logic [CNT_W-1:0]  bit_cnt;
  logic [SLOT_W-1:0] slot;
  logic              bank;

  logic [SLOT_W-1:0] last_slot;
  logic              slot_done, edge_tdm, bad, hunt_hit;
  logic [W-1:0]      i2s_exp;

  always_comb begin
    last_slot = tdm_mode ? SLOT_W'(CPF-1) : SLOT_W'(1);
    slot_done = (state == ST_TRACK) && (bit_cnt == CNT_W'(W-1));
    edge_tdm  = (fs_word[W-1:W-2] == 2'b10);
    i2s_exp   = slot[0] ? PAT_RISE_END : PAT_FALL_END;
    bad       = tdm_mode ? ((slot == last_slot) && !edge_tdm) : (fs_word != i2s_exp);
    hunt_hit  = (state == ST_HUNT) && (tdm_mode ? edge_tdm : (fs_word == PAT_RISE_END));
    emit      = hunt_hit || (slot_done && !bad);
    lost      = slot_done && bad;
    emit_slot = hunt_hit ? last_slot : slot;
    emit_bank = hunt_hit ? 1'b1 : bank;
  end
  assign tracking = (state == ST_TRACK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HUNT;
      bit_cnt <= '0;
      slot    <= '0;
      bank    <= 1'b0;
    end else if (hunt_hit) begin
      state   <= ST_TRACK;
      bit_cnt <= '0;
      slot    <= '0;
      bank    <= 1'b0;
    end else if (lost) begin
      state   <= ST_HUNT;
      bit_cnt <= '0;
      slot    <= '0;
    end else if (state == ST_TRACK) begin
      bit_cnt <= bit_cnt + CNT_W'(1);
      if (slot_done) begin
        slot <= (slot == last_slot) ? '0 : slot + SLOT_W'(1);
        if (slot == last_slot) bank <= ~bank;
      end
    end
  end

  // R7: leaving the hunt restarts tracking at the first bit of slot 0
  assert_track_start_R7: assert property (@(posedge clk) disable iff (rst)
    hunt_hit |=> (tracking && bit_cnt == '0 && slot == '0));

  // R6: a mismatch always sends the tracker back to hunting
  assert_restart_on_loss_R6: assert property (@(posedge clk) disable iff (rst)
    lost |=> !tracking);
endmodule

// File: rtl/ssm_err_tally.sv
module ssm_err_tally #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          clr,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr)              count <= '0;
    else if (inc && count != '1) count <= count + CW'(1);
  end

  assert_tally_saturates_R11: assert property (@(posedge clk) disable iff (rst)
    (count == '1 && !clr) |=> count == '1);

  assert_tally_clear_R11: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0);

  assert_tally_step_R11: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && count != '1) |=> count == $past(count) + CW'(1));
endmodule

// File: rtl/serial_audio_sync_rx.sv
module serial_audio_sync_rx #(
  parameter int CPF   = 4,
  parameter int LINES = 2,
  parameter int ERR_W = 8,
  localparam int SLOT_W = $clog2(CPF),
  localparam int DW     = LINES * ssm_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tdm_mode,
  input  logic              fsync_in,
  input  logic [LINES-1:0]  sdata_in,
  input  logic              err_clear,
  output logic              sample_valid,
  output logic [SLOT_W-1:0] sample_slot,
  output logic              sample_bank,
  output logic [DW-1:0]     sample_data,
  output logic              sync_lost,
  output logic              locked,
  output logic [ERR_W-1:0]  err_count
);
  import ssm_pkg::*;
  localparam int W = WORD_W;

  logic [W-1:0]      fs_word;
  logic [DW-1:0]     cap_words, rev_words;
  logic              emit, emit_bank, lost, tracking;
  logic [SLOT_W-1:0] emit_slot;

  ssm_capture #(.LINES(LINES)) u_capture (
    .clk(clk), .rst(rst), .fs_bit(fsync_in), .sd_bits(sdata_in),
    .fs_word(fs_word), .sd_words(cap_words)
  );

  ssm_tracker #(.CPF(CPF)) u_tracker (
    .clk(clk), .rst(rst), .tdm_mode(tdm_mode), .fs_word(fs_word),
    .emit(emit), .emit_slot(emit_slot), .emit_bank(emit_bank),
    .lost(lost), .tracking(tracking)
  );

  ssm_err_tally #(.CW(ERR_W)) u_tally (
    .clk(clk), .rst(rst), .inc(lost), .clr(err_clear), .count(err_count)
  );

  for (genvar l = 0; l < LINES; l++) begin : g_rev
    assign rev_words[l*W +: W] = rev_word(cap_words[l*W +: W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_valid <= 1'b0;
      sync_lost    <= 1'b0;
      sample_slot  <= '0;
      sample_bank  <= 1'b0;
      sample_data  <= '0;
    end else begin
      sample_valid <= emit;
      sync_lost    <= lost;
      if (emit) begin
        sample_slot <= emit_slot;
        sample_bank <= emit_bank;
        sample_data <= rev_words;
      end
    end
  end
  assign locked = tracking;

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  assert_lock_word_prev_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (sample_valid && sample_bank));

  assert_loss_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    sync_lost |-> (!sample_valid && !locked));
endmodule

// File: tb/test_serial_audio_sync_rx.sv
`timescale 1ns/1ps
module test_serial_audio_sync_rx;
  localparam int CPF = 4;
  localparam int LINES = 2;
  localparam int SW = $clog2(CPF);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst, tdm_mode, fsync_in, err_clear;
  logic [LINES-1:0]  sdata_in;
  logic              sample_valid, sample_bank, sync_lost, locked;
  logic [SW-1:0]     sample_slot;
  logic [LINES*32-1:0] sample_data;
  logic [7:0]        err_count;

  serial_audio_sync_rx #(.CPF(CPF), .LINES(LINES), .ERR_W(8)) i_serial_audio_sync_rx (
    .clk(clk), .rst(rst), .tdm_mode(tdm_mode), .fsync_in(fsync_in),
    .sdata_in(sdata_in), .err_clear(err_clear), .sample_valid(sample_valid),
    .sample_slot(sample_slot), .sample_bank(sample_bank), .sample_data(sample_data),
    .sync_lost(sync_lost), .locked(locked), .err_count(err_count)
  );

  int checks = 0, fails = 0;
  int exp_err = 0;
  bit bk = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  // Sends one 32-bit slot; fcw[b] is the frame-sync value on bit clock b.
  task automatic send_slot(input logic [31:0] fcw, input logic [63:0] d, input bit ev,
                           input int es, input bit eb, input bit el, input string tag);
    bit stray = 1'b0;
    for (int b = 0; b < 32; b++) begin
      @(negedge clk);
      fsync_in    = fcw[b];
      sdata_in[0] = d[31-b];
      sdata_in[1] = d[63-b];
      @(posedge clk);
      #1;
      if (b < 31) begin
        if (sample_valid || sync_lost) stray = 1'b1;
      end else begin
        if (el && exp_err < 255) exp_err++;
        chk(!stray, {tag, " R10 strobe mid-slot"}, 64'(stray), 64'd0);
        chk(sample_valid == ev, {tag, " valid"}, 64'(sample_valid), 64'(ev));
        chk(sync_lost == el, {tag, " R6 sync_lost"}, 64'(sync_lost), 64'(el));
        chk(err_count == 8'(exp_err), {tag, " R11 err_count"}, 64'(err_count), 64'(exp_err));
        if (ev) begin
          chk(sample_data == d, {tag, " R2 data"}, sample_data, d);
          chk(sample_slot == SW'(es), {tag, " R9 R12 slot"}, 64'(sample_slot), 64'(es));
          chk(sample_bank == eb, {tag, " R8 bank"}, 64'(sample_bank), 64'(eb));
        end
        if (el) chk(!locked, {tag, " R6 locked"}, 64'(locked), 64'd0);
      end
    end
  endtask

  task automatic i2s_frame();
    send_slot(32'h7FFF_FFFF, rnd64(), 1'b1, 0, bk, 1'b0, "R3 left");
    send_slot(32'h8000_0000, rnd64(), 1'b1, 1, bk, 1'b0, "R4 right");
    bk = ~bk;
  endtask

  task automatic tdm_frame(input bit mid_glitch);
    int h = $urandom_range(30, 1);
    send_slot((32'h1 << h) - 32'h1, rnd64(), 1'b1, 0, bk, 1'b0, "R5 hold");
    send_slot(mid_glitch ? 32'h0000_1C00 : 32'h0, rnd64(), 1'b1, 1, bk, 1'b0, "R5 mid");
    send_slot(32'h0, rnd64(), 1'b1, 2, bk, 1'b0, "R12 slot2");
    send_slot(32'h8000_0000, rnd64(), 1'b1, 3, bk, 1'b0, "R5 rise");
    bk = ~bk;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; tdm_mode = 1'b0; fsync_in = 1'b1; sdata_in = '0; err_clear = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #0.5;
    chk(!locked && !sample_valid && !sync_lost && err_count == 0, "R1 reset state",
        {locked, sample_valid, sync_lost, err_count}, 64'd0);

    // I2S: hunt, lock, steady frames
    send_slot(32'h7FFF_FFFF, rnd64(), 1'b0, 0, 1'b0, 1'b0, "R7 hunt silent");
    send_slot(32'h8000_0000, rnd64(), 1'b1, 1, 1'b1, 1'b0, "R8 lock word");
    chk(locked, "R8 locked after hunt", 64'(locked), 64'd1);
    bk = 1'b0;
    repeat (6) i2s_frame();

    // I2S left-half glitch at a random bit, then relock on the right half
    send_slot(32'h7FFF_FFFF ^ (32'h1 << $urandom_range(31, 0)), rnd64(), 1'b0, 0, 1'b0, 1'b1, "R3 bad left");
    send_slot(32'h8000_0000, rnd64(), 1'b1, 1, 1'b1, 1'b0, "R7 relock");
    bk = 1'b0;
    i2s_frame();

    // I2S right-half glitch; next left half must stay silent
    send_slot(32'h7FFF_FFFF, rnd64(), 1'b1, 0, bk, 1'b0, "R3 left");
    send_slot(32'h8000_0000 ^ (32'h1 << $urandom_range(30, 0)), rnd64(), 1'b0, 1, 1'b0, 1'b1, "R4 bad right");
    send_slot(32'h7FFF_FFFF, rnd64(), 1'b0, 0, 1'b0, 1'b0, "R7 hunt silent");
    send_slot(32'h8000_0000, rnd64(), 1'b1, 1, 1'b1, 1'b0, "R8 relock word");
    bk = 1'b0;
    i2s_frame();

    // Drive the tally into saturation
    for (int k = 0; k < 260; k++) begin
      send_slot(32'h7FFF_FFF7, rnd64(), 1'b0, 0, 1'b0, 1'b1, "R11 sat bad");
      send_slot(32'h8000_0000, rnd64(), 1'b1, 1, 1'b1, 1'b0, "R11 sat relock");
    end
    chk(err_count == 8'd255, "R11 saturated", 64'(err_count), 64'd255);
    @(negedge clk);
    err_clear = 1'b1;
    @(posedge clk);
    #1;
    chk(err_count == 8'd0, "R11 clear", 64'(err_count), 64'd0);
    @(negedge clk);
    err_clear = 1'b0;

    // TDM phase
    rst = 1'b1; tdm_mode = 1'b1; fsync_in = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_err = 0;
    send_slot(32'h0, rnd64(), 1'b0, 0, 1'b0, 1'b0, "R7 tdm hunt");
    send_slot(32'h8000_0000, rnd64(), 1'b1, 3, 1'b1, 1'b0, "R8 tdm lock");
    bk = 1'b0;
    tdm_frame(1'b0);
    tdm_frame(1'b1);
    tdm_frame(1'b0);
    tdm_frame(1'b1);

    // Early rise: both newest bits high in the check slot
    send_slot(32'h1F, rnd64(), 1'b1, 0, bk, 1'b0, "R5 hold");
    send_slot(32'h0, rnd64(), 1'b1, 1, bk, 1'b0, "R5 mid");
    send_slot(32'h0, rnd64(), 1'b1, 2, bk, 1'b0, "R12 slot2");
    send_slot(32'hC000_0000, rnd64(), 1'b0, 3, 1'b0, 1'b1, "R5 early rise");
    send_slot(32'h0000_00FF, rnd64(), 1'b0, 0, 1'b0, 1'b0, "R7 tdm silent");
    send_slot(32'h0, rnd64(), 1'b0, 0, 1'b0, 1'b0, "R7 tdm silent");
    send_slot(32'h0, rnd64(), 1'b0, 0, 1'b0, 1'b0, "R7 tdm silent");
    send_slot(32'h8000_0000, rnd64(), 1'b1, 3, 1'b1, 1'b0, "R8 tdm relock");
    bk = 1'b0;
    tdm_frame(1'b0);

    // Missing rising edge
    send_slot(32'h3, rnd64(), 1'b1, 0, bk, 1'b0, "R5 hold");
    send_slot(32'h0, rnd64(), 1'b1, 1, bk, 1'b0, "R5 mid");
    send_slot(32'h0, rnd64(), 1'b1, 2, bk, 1'b0, "R12 slot2");
    send_slot(32'h0, rnd64(), 1'b0, 3, 1'b0, 1'b1, "R5 missing rise");
    repeat (3) send_slot(32'h0, rnd64(), 1'b0, 0, 1'b0, 1'b0, "R7 tdm silent");
    send_slot(32'h8000_0000, rnd64(), 1'b1, 3, 1'b1, 1'b0, "R8 tdm relock");
    bk = 1'b0;
    tdm_frame(1'b1);
    chk(err_count == 8'd2, "R11 tdm tally", 64'(err_count), 64'd2);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule